// File: doc/BRIEF.md
# Block Coefficient Rebuilder

This block sits after a Huffman symbol matcher in a baseline image decoder. For each symbol it receives the symbol byte and the raw amplitude bits that follow it. From these it rebuilds one 8x8 block of quantized coefficients, stored in natural (row-major) order. The first symbol of a block is a DC symbol. Its value is the bit length of a signed difference. That difference is added to a running predictor for the colour component, and the sum becomes coefficient 0.

Every symbol after that is an AC symbol. Its upper nibble is a count of zero coefficients to skip, and its lower nibble is the bit length of the next nonzero amplitude. Each amplitude is sign-extended from its bit length. It is written through a scan-order to natural-order map, so coefficients arrive in diagonal scan order and are stored in raster order.

A block is closed in one of three ways: its last scan position is written, an end-of-block symbol arrives, or a skip runs past the last position, which also raises an error flag. When the block closes, a one-cycle strobe marks the coefficient bus as complete. The coefficients then stay unchanged until the next DC symbol starts a new block.

Top module: `coef_unpacker`

## Requirements
- R1: For an AC symbol, bits [7:4] give the number of zero coefficients skipped before the new one, and bits [3:0] give its amplitude length. The coefficient goes to scan position p+run, where p is the next unwritten scan position.
- R2: A DC symbol (sym_dc_i=1) takes the whole symbol value (0 to 11) as the amplitude length of the DC difference. Scan position 0 receives the result, and the next scan position becomes 1.
- R3: An amplitude of length s with low s bits v decodes to v when v >= 2^(s-1), and to v - 2^s + 1 otherwise. For example, with length 2, pattern 11 gives +3 and pattern 00 gives -3. Bits of amp_i above bit s-1 are ignored.
- R4: An amplitude length of 0 gives the value 0. An AC symbol with run r and length 0 (other than 0x00) therefore advances the scan position by r+1 and leaves zeros behind.
- R5: Scan position k is stored at natural index row*8+col, following the diagonal scan that starts 0, 1, 8, 16, 9, 2, 3, 10. Natural index n is bits [n*12 +: 12] of blk_coef_o, in two's complement.
- R6: A DC symbol clears all 64 coefficients and the error flag before writing coefficient 0, so every position not written in a block reads as zero.
- R7: AC symbol 0x00 closes the open block at once and leaves the remaining positions at zero.
- R8: AC symbol 0xF0 skips 15 zero positions and writes a 16th zero. When that zero lands on scan position 63, the block closes without error.
- R9: Each component (sym_comp_i) keeps its own predictor. The DC coefficient equals the predictor plus the difference, and it becomes the new predictor. scan_start_i clears every predictor, and a DC symbol in the same cycle sees a predictor of 0.
- R10: An AC symbol whose target scan position exceeds 63 writes nothing. It closes the block with blk_err_o=1, and the flag stays set until the next DC symbol.
- R11: blk_valid_o is 0 after reset. It is high for exactly the one cycle after the clock edge that takes in the closing symbol. After reset, all coefficients read 0.
- R12: An AC symbol that arrives while no block is open is ignored: the coefficients, blk_err_o and blk_valid_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_start_i | input | 1 | Clears all DC predictors |
| sym_valid_i | input | 1 | Symbol and amplitude are present this cycle |
| sym_dc_i | input | 1 | 1 for a DC symbol, 0 for an AC symbol |
| sym_comp_i | input | CMP_W | Component index for the DC predictor |
| sym_i | input | 8 | Symbol byte |
| amp_i | input | AMP_W | Amplitude bits, right-aligned |
| blk_valid_o | output | 1 | One-cycle strobe: the block is complete |
| blk_err_o | output | 1 | The block closed because a skip ran past position 63 |
| blk_coef_o | output | 64*COEF_W | Coefficients in natural order |

## Verification
The bench sweeps every amplitude length from 1 to 11 against every bit pattern. A design that mis-handles the threshold would turn the smallest positive value of each length into a negative value, or the reverse. It also places a single +1 at each of the 63 AC scan positions, using skip symbols to get there. A wrong map, or a skip count off by one, puts the nonzero value in the wrong cell or leaves a stale value in a later block.

Further cases cover a skip that ends exactly on position 63 and one that overruns it. A design that miscounts these either raises a false error or writes past the block. Per-component predictors are checked across a scan restart, which catches a predictor shared between components or one that is never cleared. AC symbols sent after a block closes must leave the output untouched, which catches a design that keeps writing after close.

// File: rtl/coef_pkg.sv
`timescale 1ns/1ps
package coef_pkg;
  localparam int BLK_DIM = 8;
  localparam int NPOS    = BLK_DIM * BLK_DIM;
  localparam int POS_W   = $clog2(NPOS);

  // scan index k -> natural index, packed at [k*POS_W +: POS_W]
  function automatic logic [NPOS*POS_W-1:0] build_scan_map();
    logic [NPOS*POS_W-1:0] tab;
    int k;
    tab = '0;
    k   = 0;
    for (int s = 0; s < 2*BLK_DIM-1; s++) begin
      for (int t = 0; t < BLK_DIM; t++) begin
        int r;
        int c;
        if (s % 2 == 1) r = ((s > BLK_DIM-1) ? s-(BLK_DIM-1) : 0) + t;
        else            r = ((s < BLK_DIM-1) ? s : BLK_DIM-1) - t;
        c = s - r;
        if (r >= 0 && r < BLK_DIM && c >= 0 && c < BLK_DIM && k < NPOS) begin
          tab[k*POS_W +: POS_W] = POS_W'(r*BLK_DIM + c);
          k++;
        end
      end
    end
    return tab;
  endfunction

  localparam logic [NPOS*POS_W-1:0] SCAN_MAP = build_scan_map();
endpackage

// File: rtl/coef_extend.sv
`timescale 1ns/1ps
module coef_extend #(
  parameter int AMP_W  = 11,
  parameter int COEF_W = 12
) (
  input  logic [AMP_W-1:0]  amp_i,
  input  logic [3:0]        size_i,
  output logic [COEF_W-1:0] coef_o
);
  logic [COEF_W-1:0] thr, mask, mag;

  always_comb begin
    thr  = COEF_W'(1) << (size_i - 4'd1);
    mask = (COEF_W'(1) << size_i) - COEF_W'(1);
    mag  = COEF_W'(amp_i) & mask;
    if (size_i == 4'd0)  coef_o = '0;
    else if (mag >= thr) coef_o = mag;
    else                 coef_o = mag - (thr << 1) + COEF_W'(1);
  end
endmodule

// File: rtl/coef_dc_pred.sv
`timescale 1ns/1ps
module coef_dc_pred #(
  parameter int NCOMP  = 3,
  parameter int COEF_W = 12,
  localparam int CMP_W = (NCOMP > 1) ? $clog2(NCOMP) : 1,
  localparam int NSLOT = 1 << CMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [CMP_W-1:0]  comp_i,
  input  logic [COEF_W-1:0] diff_i,
  output logic [COEF_W-1:0] dc_o
);
  logic [COEF_W-1:0] pred_q [NSLOT];

  assign dc_o = (clr_i ? '0 : pred_q[comp_i]) + diff_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSLOT; i++) pred_q[i] <= '0;
    end else begin
      if (clr_i)
        for (int i = 0; i < NSLOT; i++) pred_q[i] <= '0;
      if (upd_i) pred_q[comp_i] <= dc_o;
    end
  end
endmodule

// File: rtl/coef_scan_map.sv
`timescale 1ns/1ps
module coef_scan_map
  import coef_pkg::*;
(
  input  logic [POS_W-1:0] scan_i,
  output logic [POS_W-1:0] nat_o
);
  assign nat_o = SCAN_MAP[scan_i*POS_W +: POS_W];
endmodule

// File: rtl/coef_unpacker.sv
`timescale 1ns/1ps
module coef_unpacker
  import coef_pkg::*;
#(
  parameter int AMP_W  = 11,
  parameter int COEF_W = 12,
  parameter int NCOMP  = 3,
  localparam int CMP_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scan_start_i,
  input  logic                   sym_valid_i,
  input  logic                   sym_dc_i,
  input  logic [CMP_W-1:0]       sym_comp_i,
  input  logic [7:0]             sym_i,
  input  logic [AMP_W-1:0]       amp_i,
  output logic                   blk_valid_o,
  output logic                   blk_err_o,
  output logic [NPOS*COEF_W-1:0] blk_coef_o
);
  localparam int TGT_W = POS_W + 1;

  logic [COEF_W-1:0] coef_q [NPOS];
  logic [POS_W-1:0]  pos_q;
  logic              open_q, valid_q, err_q;

  logic [3:0]        run, size;
  logic [TGT_W-1:0]  tgt;
  logic [POS_W-1:0]  nat;
  logic [COEF_W-1:0] amp_val, dc_val;
  logic              dc_go, ac_go, eob, overrun;

  assign run     = sym_i[7:4];
  assign size    = sym_i[3:0];
  assign tgt     = TGT_W'(pos_q) + TGT_W'(run);
  assign dc_go   = sym_valid_i && sym_dc_i;
  assign ac_go   = sym_valid_i && !sym_dc_i && open_q;
  assign eob     = (sym_i == 8'h00);
  assign overrun = tgt > TGT_W'(NPOS-1);

  coef_extend #(.AMP_W(AMP_W), .COEF_W(COEF_W)) u_ext (
    .amp_i  (amp_i),
    .size_i (size),
    .coef_o (amp_val)
  );

  coef_dc_pred #(.NCOMP(NCOMP), .COEF_W(COEF_W)) u_pred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (scan_start_i),
    .upd_i  (dc_go),
    .comp_i (sym_comp_i),
    .diff_i (amp_val),
    .dc_o   (dc_val)
  );

  coef_scan_map u_map (
    .scan_i (tgt[POS_W-1:0]),
    .nat_o  (nat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPOS; i++) coef_q[i] <= '0;
      pos_q   <= '0;
      open_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (dc_go) begin
        for (int i = 1; i < NPOS; i++) coef_q[i] <= '0;
        coef_q[0] <= dc_val;
        pos_q     <= POS_W'(1);
        open_q    <= 1'b1;
        err_q     <= 1'b0;
      end else if (ac_go) begin
        if (eob) begin
          open_q  <= 1'b0;
          valid_q <= 1'b1;
        end else if (overrun) begin
          open_q  <= 1'b0;
          valid_q <= 1'b1;
          err_q   <= 1'b1;
        end else begin
          coef_q[nat] <= amp_val;
          pos_q       <= tgt[POS_W-1:0] + POS_W'(1);
          if (tgt == TGT_W'(NPOS-1)) begin
            open_q  <= 1'b0;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NPOS; g++) begin : g_out
    assign blk_coef_o[g*COEF_W +: COEF_W] = coef_q[g];
  end

  assign blk_valid_o = valid_q;
  assign blk_err_o   = err_q;
endmodule

module coef_unpacker_chk #(
  parameter int W = 768
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sym_valid_i,
  input logic         sym_dc_i,
  input logic         open_q,
  input logic         blk_valid_o,
  input logic         blk_err_o,
  input logic [W-1:0] blk_coef_o
);
  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |=> !blk_valid_o);

  assert_valid_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> $past(sym_valid_i));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> ($stable(blk_coef_o) && !blk_valid_o));

  assert_closed_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && !sym_dc_i && !open_q) |=>
      ($stable(blk_coef_o) && $stable(blk_err_o) && !blk_valid_o));

  assert_err_on_close_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_err_o) |-> blk_valid_o);

  assert_dc_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_dc_i) |=> (open_q && !blk_err_o && !blk_valid_o));
endmodule

bind coef_unpacker coef_unpacker_chk #(.W(coef_pkg::NPOS*COEF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .sym_dc_i    (sym_dc_i),
  .open_q      (open_q),
  .blk_valid_o (blk_valid_o),
  .blk_err_o   (blk_err_o),
  .blk_coef_o  (blk_coef_o)
);

// File: tb/sim_coef_unpacker.sv
`timescale 1ns/1ps
module sim_coef_unpacker;
  localparam int AMP_W = 11, COEF_W = 12, NCOMP = 3, CMP_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scan_start_i = 1'b0, sym_valid_i = 1'b0, sym_dc_i = 1'b0;
  logic [CMP_W-1:0] sym_comp_i = '0;
  logic [7:0] sym_i = '0;
  logic [AMP_W-1:0] amp_i = '0;
  logic blk_valid_o, blk_err_o;
  logic [64*COEF_W-1:0] blk_coef_o;

  int checks = 0, errors = 0;
  logic got_v, got_e;

  always #4 clk_i = ~clk_i;

  coef_unpacker #(.AMP_W(AMP_W), .COEF_W(COEF_W), .NCOMP(NCOMP)) u0 (.*);

  function automatic int cf(int n);
    return int'($signed(blk_coef_o[n*COEF_W +: COEF_W]));
  endfunction

  function automatic int zz_ref(int p);
    int r = 0, c = 0;
    for (int i = 0; i < p; i++) begin
      if ((r + c) % 2 == 0) begin
        if (c == 7) r++;
        else if (r == 0) c++;
        else begin r--; c++; end
      end else begin
        if (r == 7) c++;
        else if (c == 0) r++;
        else begin r++; c--; end
      end
    end
    return r*8 + c;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(logic dc, int comp, int s, int amp);
    sym_valid_i = 1'b1;
    sym_dc_i    = dc;
    sym_comp_i  = CMP_W'(comp);
    sym_i       = 8'(s);
    amp_i       = AMP_W'(amp);
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    got_v = blk_valid_o;
    got_e = blk_err_o;
  endtask

  task automatic scan_restart();
    scan_start_i = 1'b1;
    @(negedge clk_i);
    scan_start_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp;
    int rem;
    int tz;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    check("R11 reset valid", int'(blk_valid_o), 0);
    check("R10 reset err", int'(blk_err_o), 0);
    for (int n = 0; n < 64; n++) check("R11 reset coef", cf(n), 0);

    // R3 / R1: every length and pattern at scan position 1
    for (int s = 1; s <= 11; s++) begin
      for (int v = 0; v < (1 << s); v++) begin
        put(1'b1, 0, 0, 0);
        put(1'b0, 0, s, v | (1 << 10 << 1) | ((s < 11) ? (1 << s) : 0));
        exp = (v >= (1 << (s-1))) ? v : -(((~v) & ((1 << s) - 1)));
        check("R3 extend", cf(1), exp);
        put(1'b0, 0, 8'h00, 0);
        check("R7 eob close", int'(got_v), 1);
      end
    end

    // R5 / R1 / R8 / R6: +1 at each AC scan position
    for (int p = 1; p < 64; p++) begin
      put(1'b1, 0, 0, 0);
      rem = p - 1;
      while (rem >= 16) begin
        put(1'b0, 0, 8'hF0, 0);
        check("R8 zrl no close", int'(got_v), 0);
        rem -= 16;
      end
      put(1'b0, 0, (rem << 4) | 1, 1);
      if (p == 63) begin
        check("R11 close at 63", int'(got_v), 1);
        check("R10 no err at 63", int'(got_e), 0);
      end else begin
        check("R11 no early close", int'(got_v), 0);
        put(1'b0, 0, 8'h00, 0);
        check("R7 eob", int'(got_v), 1);
      end
      for (int n = 0; n < 64; n++)
        check("R5 placement", cf(n), (n == zz_ref(p)) ? 1 : 0);
      // R12: closed block ignores AC symbols
      put(1'b0, 0, 8'h01, 1);
      check("R12 no strobe", int'(got_v), 0);
      check("R12 coef kept", cf(zz_ref(p)), 1);
    end

    // R9 / R2 predictors
    scan_restart();
    put(1'b1, 0, 3, 5);
    check("R9 comp0 first", cf(0), 5);
    put(1'b1, 0, 2, 0);
    check("R2 dc size2 -3", cf(0), 2);
    put(1'b1, 1, 2, 3);
    check("R9 comp1 separate", cf(0), 3);
    put(1'b1, 0, 0, 0);
    check("R9 comp0 held", cf(0), 2);
    put(1'b1, 2, 11, 2047);
    check("R2 dc size11", cf(0), 2047);
    scan_restart();
    put(1'b1, 0, 1, 1);
    check("R9 scan clear", cf(0), 1);
    scan_start_i = 1'b1;
    put(1'b1, 1, 1, 0);
    scan_start_i = 1'b0;
    check("R9 same-cycle clear", cf(0), -1);

    // R10 overrun
    put(1'b1, 0, 0, 0);
    put(1'b0, 0, 8'hF1, 1);
    put(1'b0, 0, 8'hF1, 1);
    put(1'b0, 0, 8'hF1, 1);
    check("R10 no err yet", int'(got_v), 0);
    put(1'b0, 0, 8'hF1, 1);
    check("R10 close", int'(got_v), 1);
    check("R10 err", int'(got_e), 1);
    check("R1 pos16", cf(zz_ref(16)), 1);
    check("R1 pos48", cf(zz_ref(48)), 1);
    check("R10 nothing past", cf(zz_ref(63)), 0);
    put(1'b0, 0, 8'h01, 1);
    check("R12 ignored after err", int'(got_v), 0);
    check("R12 err held", int'(got_e), 1);
    check("R12 pos49 untouched", cf(zz_ref(49)), 0);
    put(1'b1, 0, 0, 0);
    check("R6 err cleared", int'(got_e), 0);
    check("R6 cleared coef", cf(zz_ref(16)), 0);

    // R8: zrl landing exactly on 63
    put(1'b0, 0, 8'hE1, 1);
    put(1'b0, 0, 8'hF0, 0);
    put(1'b0, 0, 8'hF0, 0);
    check("R8 still open", int'(got_v), 0);
    put(1'b0, 0, 8'hF0, 0);
    check("R8 close at 63", int'(got_v), 1);
    check("R8 no err", int'(got_e), 0);
    check("R8 pos15", cf(zz_ref(15)), 1);

    // R4: run with zero length
    put(1'b1, 0, 0, 0);
    put(1'b0, 0, 8'h30, 7);
    put(1'b0, 0, 8'h01, 0);
    tz = 0;
    for (int n = 1; n < 64; n++) if (n != zz_ref(5)) tz += (cf(n) != 0);
    check("R4 zeros", tz, 0);
    check("R4 advance", cf(zz_ref(5)), -1);
    put(1'b0, 0, 8'h00, 0);
    check("R7 eob", int'(got_v), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule